// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block runs on a system clock and drives an external asynchronous static RAM of 8192 bytes. The RAM has no clock. The user side takes one read or one write at a time through a valid/ready handshake, with a 13-bit word address and an 8-bit write byte. A read returns its byte together with a single-cycle done strobe.

On the memory side the block drives a registered address, active-low chip-enable, output-enable and write-enable, and a data bus. The data bus is split into an output value, an output drive enable, and an input from the pads. Every nanosecond limit of the memory enters as a parameter. The block turns each limit into a whole number of clock cycles from a clock-period parameter, rounding up, with a floor of one cycle. Nothing else needs to change when the clock frequency changes.

The controller keeps the memory in standby while no access is running. It never lets its own data drivers overlap a window in which the memory may still be driving the shared pins.

Top module: `sram_ctl`

## Requirements
- R1: While reset is held and on the first cycle after it, chip-enable, output-enable and write-enable are all high (inactive), the data drive enable is low, ready is high and done is low.
- R2: Whenever ready is high (no access in progress), chip-enable is high and the data drive enable is low, so the memory sits in standby with the bus released.
- R3: A read drives chip-enable low, output-enable low and write-enable high, with the data drive enable low. This combination is held for max(ceil(70/T), ceil(35/T)) cycles, where T is the clock period in ns. That is 7 cycles at T=10.
- R4: The read byte is sampled on the last cycle of that window. It appears on the read-data output in the cycle after, with done high for exactly one cycle.
- R5: A write keeps output-enable high and holds chip-enable and write-enable low together for at least ceil(60/T) cycles (6 at T=10). The write byte is driven unchanged for at least ceil(30/T) cycles (3 at T=10) before write-enable rises.
- R6: The data drive enable is high only while write-enable is low. It drops on the same clock edge at which write-enable rises. It is never high while output-enable is low, nor during the ceil(25/T) cycles (3 at T=10) after output-enable rises.
- R7: Ready falls on the cycle after a request is accepted. It rises again ceil(70/T) cycles after the accepting edge, for reads and for writes, including a write that directly follows a read.
- R8: A request is accepted only on an edge where valid and ready are both high. Address, direction and write byte are taken from that edge, and valid held high while busy starts nothing.
- R9: Each limit is converted as ceil(t/T) with a minimum of one. At T=10 a write with the bus already turned around holds write-enable low for exactly 6 cycles.
- R10: The memory address output does not change from the accepting edge until ready rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (13) | Word address |
| req_wdata | input | DATA_W (8) | Byte to write |
| rsp_done | output | 1 | One-cycle strobe with read data |
| rsp_rdata | output | DATA_W (8) | Byte returned by the last read |
| sram_addr | output | ADDR_W (13) | Address to the memory |
| sram_ce_n | output | 1 | Chip-enable, active low |
| sram_oe_n | output | 1 | Output-enable, active low |
| sram_we_n | output | 1 | Write-enable, active low |
| sram_dq_out | output | DATA_W (8) | Byte driven onto the data pins |
| sram_dq_oe | output | 1 | Drive enable for the data pins |
| sram_dq_in | input | DATA_W (8) | Byte read from the data pins |

## Verification
A behavioural memory model in the bench returns a corrupted byte when an access window is shorter than the limits allow, and stores a corrupted byte when a write pulse or data setup is too short. A miscounted phase counter or a wrong state transition therefore shows up as a wrong read value on the very next read of that address. The model also tracks when the memory may still be driving the pins and flags any cycle where the controller drives at the same time. A turnaround counter that is off by one is caught in the cycle where it happens. Latency and pulse widths are measured on every access, so a timing slip shows up within the same transaction.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_READ    = 2'd1,
    ST_WRITE   = 2'd2,
    ST_RECOVER = 2'd3
  } seq_state_e;

  // Round a nanosecond limit up to whole clock cycles, never below one.
  function automatic int ns_to_cycles(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_turn.sv
module sram_ctl_turn #(
  parameter int N_HZ = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic oe_n,
  input  logic dq_oe,
  output logic drive_ok
);
  localparam int GAP_W = (N_HZ < 1) ? 1 : $clog2(N_HZ + 1);
  localparam logic [GAP_W-1:0] GAP_FULL = GAP_W'(N_HZ);

  logic [GAP_W-1:0] gap_q;
  logic [GAP_W-1:0] gap_nx;

  // Counts whole cycles with output-enable released, saturating at the limit.
  always_comb begin
    if (!oe_n)              gap_nx = '0;
    else if (gap_q == GAP_FULL) gap_nx = gap_q;
    else                    gap_nx = gap_q + 1'b1;
  end

  assign drive_ok = (gap_nx >= GAP_FULL);

  always_ff @(posedge clk) begin
    if (rst) gap_q <= GAP_FULL;
    else     gap_q <= gap_nx;
  end

  // R6: data is only driven once the memory has had time to let go of the bus
  p_turnaround_r6: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> (gap_q >= GAP_FULL));

endmodule

// File: rtl/sram_ctl_rdcap.sv
module sram_ctl_rdcap #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] din,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      rdata <= '0;
    end else begin
      done <= cap_en;
      if (cap_en) rdata <= din;
    end
  end

  // R4: done lasts a single cycle
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int N_RD   = 7,
  parameter int N_WL   = 6,
  parameter int N_WC   = 7,
  parameter int N_DW   = 3,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              drive_ok,
  output logic              req_ready,
  output logic              cap_en,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              ce_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(N_RD);
  localparam logic [CNT_W-1:0] WL_MIN  = CNT_W'(N_WL);
  localparam logic [CNT_W-1:0] WC_MIN  = CNT_W'(N_WC);
  localparam logic [CNT_W-1:0] DW_MIN  = CNT_W'(N_DW);

  seq_state_e       state;
  logic [CNT_W-1:0] cnt;       // index of the current access cycle, first = 1
  logic [CNT_W-1:0] dcnt;      // driven cycles completed before this one
  logic [CNT_W-1:0] dcnt_done;
  logic             we_end;

  assign dcnt_done = dcnt + {{(CNT_W-1){1'b0}}, dq_oe};
  assign we_end    = (cnt >= WL_MIN) && (dcnt_done >= DW_MIN);
  assign cap_en    = (state == ST_READ) && (cnt == RD_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      req_ready <= 1'b1;
      ce_n      <= 1'b1;
      oe_n      <= 1'b1;
      we_n      <= 1'b1;
      dq_oe     <= 1'b0;
      dq_out    <= '0;
      sram_addr <= '0;
      cnt       <= '0;
      dcnt      <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            req_ready <= 1'b0;
            sram_addr <= req_addr;
            ce_n      <= 1'b0;
            cnt       <= CNT_W'(1);
            dcnt      <= '0;
            if (req_write) begin
              dq_out <= req_wdata;
              we_n   <= 1'b0;
              dq_oe  <= drive_ok;
              state  <= ST_WRITE;
            end else begin
              oe_n  <= 1'b0;
              state <= ST_READ;
            end
          end
        end
        ST_READ: begin
          if (cnt == RD_LAST) begin
            ce_n      <= 1'b1;
            oe_n      <= 1'b1;
            req_ready <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WRITE: begin
          cnt  <= cnt + 1'b1;
          dcnt <= dcnt_done;
          if (we_end) begin
            we_n  <= 1'b1;
            ce_n  <= 1'b1;
            dq_oe <= 1'b0;
            if (cnt >= WC_MIN) begin
              req_ready <= 1'b1;
              state     <= ST_IDLE;
            end else begin
              state <= ST_RECOVER;
            end
          end else begin
            dq_oe <= dq_oe | drive_ok;
          end
        end
        ST_RECOVER: begin
          cnt <= cnt + 1'b1;
          if (cnt >= WC_MIN) begin
            req_ready <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: idle means standby and a released bus
  p_standby_r2: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (ce_n && oe_n && we_n && !dq_oe));

  // R3: output-enable low only in the read encoding
  p_read_enc_r3: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> (!ce_n && we_n && !dq_oe));

  // R5: output-enable stays high through a write
  p_write_enc_r5: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (oe_n && !ce_n));

  // R6: drivers only on while write-enable is low
  p_drive_in_write_r6: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> !we_n);

  // R6: drivers let go on the edge write-enable rises
  p_release_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> !dq_oe);

  // R10: address held for the whole access
  p_addr_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && $past(!req_ready)) |-> $stable(sram_addr));

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int CLK_NS  = 10,
  parameter int ADDR_W  = 13,
  parameter int DATA_W  = 8,
  parameter int T_RC_NS = 70,
  parameter int T_AA_NS = 70,
  parameter int T_OE_NS = 35,
  parameter int T_WP_NS = 50,
  parameter int T_CW_NS = 60,
  parameter int T_AW_NS = 60,
  parameter int T_WC_NS = 70,
  parameter int T_DW_NS = 30,
  parameter int T_HZ_NS = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);
  localparam int N_RD = imax(imax(ns_to_cycles(T_RC_NS, CLK_NS),
                                  ns_to_cycles(T_AA_NS, CLK_NS)),
                             ns_to_cycles(T_OE_NS, CLK_NS));
  localparam int N_WL = imax(ns_to_cycles(T_WP_NS, CLK_NS),
                             imax(ns_to_cycles(T_CW_NS, CLK_NS),
                                  ns_to_cycles(T_AW_NS, CLK_NS)));
  localparam int N_WC = ns_to_cycles(T_WC_NS, CLK_NS);
  localparam int N_DW = ns_to_cycles(T_DW_NS, CLK_NS);
  localparam int N_HZ = ns_to_cycles(T_HZ_NS, CLK_NS);
  localparam int CNT_MAX = N_RD + N_WL + N_WC + N_DW + N_HZ + 2;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic drive_ok;
  logic cap_en;

  sram_ctl_turn #(.N_HZ(N_HZ)) u_turn (
    .clk      (clk),
    .rst      (rst),
    .oe_n     (sram_oe_n),
    .dq_oe    (sram_dq_oe),
    .drive_ok (drive_ok)
  );

  sram_ctl_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .N_RD   (N_RD),
    .N_WL   (N_WL),
    .N_WC   (N_WC),
    .N_DW   (N_DW),
    .CNT_W  (CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .drive_ok  (drive_ok),
    .req_ready (req_ready),
    .cap_en    (cap_en),
    .sram_addr (sram_addr),
    .ce_n      (sram_ce_n),
    .oe_n      (sram_oe_n),
    .we_n      (sram_we_n),
    .dq_out    (sram_dq_out),
    .dq_oe     (sram_dq_oe)
  );

  sram_ctl_rdcap #(.DATA_W(DATA_W)) u_rdcap (
    .clk    (clk),
    .rst    (rst),
    .cap_en (cap_en),
    .din    (sram_dq_in),
    .done   (rsp_done),
    .rdata  (rsp_rdata)
  );

  // R6: never drive against a memory that has its outputs enabled
  p_no_fight_r6: assert property (@(posedge clk) disable iff (rst)
    sram_dq_oe |-> sram_oe_n);

  // R8: a new access begins only from an accepted request
  p_accept_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(sram_ce_n) |-> $past(req_valid && req_ready));

endmodule

// File: tb/sram_ctl_tb.sv
module sram_ctl_tb;
  localparam int CLK = 10;
  localparam int AW  = 11;
  localparam int DW  = 8;
  localparam int WORDS = 1 << AW;

  function automatic int cyc_of(input int t);
    int c;
    c = (t + CLK - 1) / CLK;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_RD  = mx(cyc_of(70), cyc_of(35));
  localparam int E_WL  = mx(cyc_of(50), cyc_of(60));
  localparam int E_DW  = cyc_of(30);
  localparam int E_HZ  = cyc_of(25);
  localparam int E_LAT = cyc_of(70);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_done;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] sram_addr;
  logic sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [DW-1:0] sram_dq_out;
  logic [DW-1:0] sram_dq_in = '0;

  sram_ctl #(.CLK_NS(CLK), .ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
    .sram_dq_in(sram_dq_in)
  );

  always #(CLK/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // ---------------- memory model ----------------
  logic [DW-1:0] model_mem [WORDS];
  logic [DW-1:0] exp_mem   [WORDS];
  int wl_obs = 0, ds_obs = 0, rd_obs = 0, rel = 15;
  logic [DW-1:0] ds_val = '0;
  logic [AW-1:0] w_addr = '0, r_addr = '0, busy_addr = '0;
  int fights = 0, standby_bad = 0, enc_bad = 0, addr_moves = 0;
  bit busy_prev = 1'b0;
  bit model_on = 1'b0;

  always @(negedge clk) begin
    if (model_on) begin
      bit wr_now, rd_now, drv;
      wr_now = !sram_ce_n && !sram_we_n;
      rd_now = !sram_ce_n && !sram_oe_n && sram_we_n;
      // write tracking
      if (wr_now) begin
        wl_obs++;
        w_addr = sram_addr;
        if (sram_dq_oe) begin
          if (ds_obs > 0 && sram_dq_out == ds_val) ds_obs++;
          else begin ds_obs = 1; ds_val = sram_dq_out; end
        end else ds_obs = 0;
      end else if (wl_obs > 0) begin
        check(wl_obs >= E_WL, "R5 write pulse cycles", wl_obs, E_WL);
        check(wl_obs == E_WL, "R9 write pulse exact", wl_obs, E_WL);
        check(ds_obs >= E_DW, "R5 data setup cycles", ds_obs, E_DW);
        check(!sram_dq_oe, "R6 release with we rise", sram_dq_oe, 0);
        model_mem[w_addr] = (wl_obs >= E_WL && ds_obs >= E_DW) ? ds_val : ~ds_val;
        wl_obs = 0;
        ds_obs = 0;
      end
      // read tracking
      if (rd_now) begin
        if (rd_obs > 0 && sram_addr == r_addr) rd_obs++;
        else rd_obs = 1;
        r_addr = sram_addr;
        sram_dq_in = (rd_obs >= E_RD) ? model_mem[sram_addr] : ~model_mem[sram_addr];
      end else rd_obs = 0;
      // bus ownership: memory may drive up to E_HZ cycles after release
      if (rd_now) rel = 0;
      else if (rel < 15) rel++;
      drv = rd_now || (rel >= 1 && rel <= E_HZ);
      if (drv && sram_dq_oe) fights++;
      // standby and encodings
      if (req_ready && (!sram_ce_n || sram_dq_oe)) standby_bad++;
      if (!sram_oe_n && (!sram_we_n || sram_ce_n)) enc_bad++;
      if (!sram_we_n && !sram_oe_n) enc_bad++;
      if (busy_prev && !req_ready && sram_addr != busy_addr) addr_moves++;
      busy_prev = !req_ready;
      busy_addr = sram_addr;
    end
  end

  // ---------------- access task ----------------
  task automatic access(input bit wr, input int a, input logic [DW-1:0] d,
                        input int decoy, input logic [DW-1:0] exp_rd);
    int acc;
    bit saw_done;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    acc = cyc;
    if (decoy > 0) begin
      req_addr = AW'(a + 1); req_wdata = 8'hEE; req_write = 1'b1;
      repeat (decoy) @(negedge clk);
    end
    req_valid = 1'b0;
    saw_done = 1'b0;
    while (!req_ready) begin
      if (rsp_done) saw_done = 1'b1;
      @(negedge clk);
    end
    check(cyc - acc == E_LAT, "R7 ready latency", cyc - acc, E_LAT);
    if (wr) begin
      check(!saw_done && !rsp_done, "R4 no done on write", rsp_done, 0);
      exp_mem[a] = d;
    end else begin
      check(rsp_done && !saw_done, "R4 done with ready", rsp_done, 1);
      check(rsp_rdata == exp_rd, "R4 read data", rsp_rdata, exp_rd);
      @(negedge clk);
      check(!rsp_done, "R4 done one cycle", rsp_done, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) begin
      model_mem[i] = 8'h00;
      exp_mem[i]   = 8'h00;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(req_ready && sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe && !rsp_done,
          "R1 reset state", {req_ready, sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe, rsp_done}, 6'b111100);
    rst = 1'b0;
    model_on = 1'b1;
    @(negedge clk);
    check(req_ready && sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe && !rsp_done,
          "R1 first cycle out of reset", {req_ready, sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe, rsp_done}, 6'b111100);
    // sweep: write every word, then read every word
    for (int a = 0; a < WORDS; a++) access(1'b1, a, DW'(a * 7 + (a >> 8) + 3), 0, 8'h00);
    for (int a = 0; a < WORDS; a++) access(1'b0, a, 8'h00, 0, exp_mem[a]);
    // read followed directly by write: turnaround path
    for (int k = 0; k < 64; k++) begin
      int a;
      a = WORDS - 1 - k * 5;
      access(1'b0, a, 8'h00, 0, exp_mem[a]);
      access(1'b1, a, DW'(8'hA5 ^ k), 0, 8'h00);
      access(1'b0, a, 8'h00, 0, exp_mem[a]);
    end
    // R8: valid held with other address while busy starts nothing
    access(1'b1, 20, 8'h3C, 3, 8'h00);
    access(1'b0, 21, 8'h00, 0, exp_mem[21]);
    access(1'b0, 20, 8'h00, 0, 8'h3C);
    check(exp_mem[21] != 8'hEE, "R8 decoy not written", exp_mem[21], 0);
    repeat (4) @(negedge clk);
    check(fights == 0, "R6 bus contention cycles", fights, 0);
    check(standby_bad == 0, "R2 standby violations", standby_bad, 0);
    check(enc_bad == 0, "R3 encoding violations", enc_bad, 0);
    check(addr_moves == 0, "R10 address changes while busy", addr_moves, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog R7: actual %0d expected %0d", cyc, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule